// File: doc/BRIEF.md
# Single-Precision Float to Fixed-Point Converter

This block takes one IEEE-754 binary32 operand and turns it into a fixed-point integer of 16, 32 or 64 bits, signed or unsigned. Before rounding, the operand is scaled up by a programmable number of fractional bits (0 to 63). The scaled value is then rounded to an integer under one of five rounding modes. A result that does not fit the chosen width is clamped to the nearest limit of that width. Two exception flags come out with every result: invalid and inexact.

Operands and their controls travel together on a valid/ready input stream. Results leave on a valid/ready output stream through a single register stage. An operand is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or its contents are being taken on the same edge, so throughput is one conversion per clock when `out_ready` stays high. A result that is not taken stays unchanged on the output. While the output waits, no new operand is accepted.

The conversion itself is combinational from the input payload to the output register. Flags are not accumulated between operations.

Top module: `f2x_conv`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. An operand accepted on one edge shows its result with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result and the flags hold their values.
- R2: The operand is multiplied by 2 to the power `in_fbits` (0 to 63) before rounding. A scaled value that is an exact in-range integer is delivered with both flags clear.
- R3: `in_rmode` selects the rounding: 0 = nearest with ties to even, 1 = toward +infinity, 2 = toward -infinity, 3 = toward zero, 4 = nearest with ties away from zero. Codes 5, 6 and 7 act as code 3.
- R4: Inexact is raised when the rounded integer differs from the scaled value and the result is in range. Invalid and inexact are never both set.
- R5: For a signed conversion, a rounded value above the width maximum gives 2^(W-1)-1 and one below the width minimum gives -2^(W-1). In both cases invalid is set and inexact is cleared.
- R6: For an unsigned conversion, a rounded value below zero gives 0 with invalid set and inexact clear. A negative operand that rounds to zero, or -0, gives 0 with no invalid.
- R7: For an unsigned conversion, a rounded value above 2^W-1 gives 2^W-1 with invalid set and inexact clear.
- R8: A NaN operand, quiet or signalling and of either sign, gives a result of 0 with invalid set and inexact clear.
- R9: Plus and minus infinity count as out of range and saturate by sign and signedness, as in R5, R6 and R7, with invalid set.
- R10: `in_wsel` 0 selects W=16, 1 selects W=32, and 2 or 3 select W=64. Signed results are sign-extended to 64 bits and unsigned results are zero-extended.
- R11: Subnormal operands are converted by their exact value. They round to zero, or to one unit away from zero, according to the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand payload valid |
| in_ready | output | 1 | Converter can take an operand |
| in_op | input | 32 | Binary32 operand |
| in_signed | input | 1 | 1 = signed destination, 0 = unsigned |
| in_wsel | input | 2 | Destination width select (R10) |
| in_fbits | input | 6 | Number of fractional bits of the destination |
| in_rmode | input | 3 | Rounding mode code (R3) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Fixed-point result, extended to 64 bits |
| out_invalid | output | 1 | Invalid-operation flag for this result |
| out_inexact | output | 1 | Inexact flag for this result |

## Verification
Random operands are drawn with exponents concentrated where the scaled value lands near the integer range. This places the rounding point inside the mantissa and separates the five modes through their guard and sticky decisions; operands with cleared low mantissa bits make exact halves common, which is the only place nearest-even and nearest-away differ. Directed operands sit exactly on and one step past each width limit, for both signednesses, so off-by-one errors in the saturation compares show up. Zeros, subnormals, infinities and NaNs are also applied directly, and a large fraction-bit count is combined with unit operands to check the scaling. One sequence stalls the output with a second operand waiting, which shows whether the held result is overwritten or the waiting operand is lost.

// File: rtl/f2x_pkg.sv
package f2x_pkg;

  localparam int FP_W     = 32;
  localparam int MAN_W    = 23;
  localparam int EXP_W    = 8;
  localparam int SIG_W    = MAN_W + 1;
  localparam int EXP_BIAS = 127;

  localparam logic [2:0] RM_NEAR_EVEN = 3'd0;
  localparam logic [2:0] RM_POS_INF   = 3'd1;
  localparam logic [2:0] RM_NEG_INF   = 3'd2;
  localparam logic [2:0] RM_TO_ZERO   = 3'd3;
  localparam logic [2:0] RM_NEAR_AWAY = 3'd4;

  typedef struct packed {
    logic             sign;
    logic [EXP_W:0]   exp_eff;
    logic [SIG_W-1:0] sig;
    logic             is_nan;
    logic             is_inf;
  } fp_fields_t;

endpackage

// File: rtl/f2x_unpack.sv
module f2x_unpack
  import f2x_pkg::*;
(
  input  logic [FP_W-1:0] op,
  output fp_fields_t      fld
);

  logic [EXP_W-1:0] ef;
  logic [MAN_W-1:0] mf;
  logic             e_zero;
  logic             e_max;

  assign ef     = op[FP_W-2 -: EXP_W];
  assign mf     = op[MAN_W-1:0];
  assign e_zero = (ef == '0);
  assign e_max  = (ef == '1);

  always_comb begin
    fld.sign    = op[FP_W-1];
    // subnormals share the exponent of the smallest normal
    fld.exp_eff = e_zero ? (EXP_W+1)'(1) : {1'b0, ef};
    fld.sig     = {!e_zero, mf};
    fld.is_nan  = e_max && (mf != '0);
    fld.is_inf  = e_max && (mf == '0);
  end

endmodule

// File: rtl/f2x_scale_round.sv
module f2x_scale_round
  import f2x_pkg::*;
#(
  parameter int FRAC_W = 6,
  parameter int RES_W  = 64
) (
  input  fp_fields_t        fld,
  input  logic [FRAC_W-1:0] fbits,
  input  logic [2:0]        rmode,
  output logic [RES_W:0]    mag,
  output logic              huge,
  output logic              lost
);

  localparam int SH_W    = ((EXP_W + 1 > FRAC_W) ? EXP_W + 1 : FRAC_W) + 2;
  localparam int MAX_LSH = RES_W - SIG_W;
  localparam int LSH_W   = $clog2(MAX_LSH + 1);
  localparam int RSH_W   = $clog2(SIG_W + 1);
  localparam int BASE    = EXP_BIAS + MAN_W;

  logic signed [SH_W-1:0] k;
  logic [SH_W-1:0]        rsh;
  logic [2*SIG_W-1:0]     rwin;
  logic [SIG_W-1:0]       ipart;
  logic                   guard;
  logic                   sticky;
  logic                   inc;

  // binary point position relative to the significand lsb
  assign k    = $signed(SH_W'(fld.exp_eff)) + $signed(SH_W'(fbits))
              - $signed(SH_W'(BASE));
  assign rsh  = -k;
  assign rwin = {fld.sig, {SIG_W{1'b0}}} >> rsh[RSH_W-1:0];

  always_comb begin
    mag    = '0;
    huge   = 1'b0;
    ipart  = '0;
    guard  = 1'b0;
    sticky = 1'b0;
    if (fld.is_inf || fld.is_nan) begin
      huge = 1'b1;
    end else if (!k[SH_W-1]) begin
      if (k > $signed(SH_W'(MAX_LSH))) huge = 1'b1;
      else mag = (RES_W+1)'(fld.sig) << k[LSH_W-1:0];
    end else if (rsh <= SH_W'(SIG_W)) begin
      ipart  = rwin[2*SIG_W-1 -: SIG_W];
      guard  = rwin[SIG_W-1];
      sticky = |rwin[SIG_W-2:0];
    end else begin
      sticky = |fld.sig;
    end

    case (rmode)
      RM_NEAR_EVEN: inc = guard & (sticky | ipart[0]);
      RM_POS_INF:   inc = !fld.sign & (guard | sticky);
      RM_NEG_INF:   inc = fld.sign & (guard | sticky);
      RM_NEAR_AWAY: inc = guard;
      default:      inc = 1'b0;
    endcase

    if (k[SH_W-1]) mag = (RES_W+1)'(ipart) + (RES_W+1)'(inc);
    lost = guard | sticky;
  end

endmodule

// File: rtl/f2x_saturate.sv
module f2x_saturate #(
  parameter int RES_W  = 64,
  parameter int NUM_W  = 3,
  parameter int MIN_W  = 16,
  parameter int WSEL_W = 2
) (
  input  logic              sign,
  input  logic [RES_W:0]    mag,
  input  logic              huge,
  input  logic              is_nan,
  input  logic              is_signed,
  input  logic [WSEL_W-1:0] wsel,
  input  logic              lost,
  output logic [RES_W-1:0]  result,
  output logic              invalid,
  output logic              inexact
);

  localparam int SEL_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;

  logic [NUM_W-1:0][RES_W-1:0] res_w;
  logic [NUM_W-1:0]            inv_w;
  logic [RES_W-1:0]            neg_mag;
  logic [SEL_W-1:0]            sel;

  assign neg_mag = -mag[RES_W-1:0];

  for (genvar gi = 0; gi < NUM_W; gi++) begin : g_width
    localparam int W = MIN_W << gi;
    localparam logic [RES_W:0]   S_LIM = (RES_W+1)'(1) << (W - 1);
    localparam logic [RES_W:0]   U_LIM = (RES_W+1)'(1) << W;
    localparam logic [RES_W-1:0] S_MAX = RES_W'(S_LIM - 1);
    localparam logic [RES_W-1:0] S_MIN = ~S_MAX;
    localparam logic [RES_W-1:0] U_MAX = {RES_W{1'b1}} >> (RES_W - W);

    logic [RES_W-1:0] r;
    logic             v;

    always_comb begin
      if (is_signed) begin
        if (sign) begin
          v = huge || (mag > S_LIM);
          r = v ? S_MIN : neg_mag;
        end else begin
          v = huge || (mag >= S_LIM);
          r = v ? S_MAX : mag[RES_W-1:0];
        end
      end else if (sign) begin
        v = huge || (mag != '0);
        r = '0;
      end else begin
        v = huge || (mag >= U_LIM);
        r = v ? U_MAX : mag[RES_W-1:0];
      end
    end

    assign res_w[gi] = r;
    assign inv_w[gi] = v;
  end

  assign sel = (int'(wsel) >= NUM_W - 1) ? SEL_W'(NUM_W - 1) : SEL_W'(wsel);

  always_comb begin
    if (is_nan) begin
      result  = '0;
      invalid = 1'b1;
    end else begin
      result  = res_w[sel];
      invalid = inv_w[sel];
    end
    inexact = lost && !invalid;
  end

endmodule

// File: rtl/f2x_conv.sv
module f2x_conv
  import f2x_pkg::*;
#(
  parameter int FRAC_W = 6,
  parameter int RES_W  = 64,
  parameter int NUM_W  = 3,
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FP_W-1:0]   in_op,
  input  logic              in_signed,
  input  logic [WSEL_W-1:0] in_wsel,
  input  logic [FRAC_W-1:0] in_fbits,
  input  logic [2:0]        in_rmode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RES_W-1:0]  out_result,
  output logic              out_invalid,
  output logic              out_inexact
);

  localparam int MIN_W = RES_W >> (NUM_W - 1);

  fp_fields_t       fld;
  logic [RES_W:0]   mag;
  logic             huge;
  logic             lost;
  logic [RES_W-1:0] c_result;
  logic             c_invalid;
  logic             c_inexact;

  f2x_unpack u_unpack (
    .op  (in_op),
    .fld (fld)
  );

  f2x_scale_round #(
    .FRAC_W (FRAC_W),
    .RES_W  (RES_W)
  ) u_round (
    .fld   (fld),
    .fbits (in_fbits),
    .rmode (in_rmode),
    .mag   (mag),
    .huge  (huge),
    .lost  (lost)
  );

  f2x_saturate #(
    .RES_W  (RES_W),
    .NUM_W  (NUM_W),
    .MIN_W  (MIN_W),
    .WSEL_W (WSEL_W)
  ) u_sat (
    .sign      (fld.sign),
    .mag       (mag),
    .huge      (huge),
    .is_nan    (fld.is_nan),
    .is_signed (in_signed),
    .wsel      (in_wsel),
    .lost      (lost),
    .result    (c_result),
    .invalid   (c_invalid),
    .inexact   (c_inexact)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= c_result;
        out_invalid <= c_invalid;
        out_inexact <= c_inexact;
      end
    end
  end

  // R1
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_invalid) && $stable(out_inexact));

  // R1
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R4
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));

  // R8
  nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op[FP_W-2 -: EXP_W] == '1) && (in_op[MAN_W-1:0] != '0)
      |=> out_result == '0 && out_invalid && !out_inexact);

  // R10
  sext_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_signed && in_wsel == '0
      |=> ($countones(out_result[RES_W-1:MIN_W-1]) == 0)
       || ($countones(out_result[RES_W-1:MIN_W-1]) == RES_W - MIN_W + 1));

  // R10
  zext_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_signed && in_wsel == '0
      |=> out_result[RES_W-1:MIN_W] == '0);

endmodule

// File: tb/f2x_conv_bench.sv
module f2x_conv_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_op = '0;
  logic        in_signed = 1'b0;
  logic [1:0]  in_wsel = '0;
  logic [5:0]  in_fbits = '0;
  logic [2:0]  in_rmode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_invalid;
  logic        out_inexact;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  f2x_conv u_f2x_conv (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_op       (in_op),
    .in_signed   (in_signed),
    .in_wsel     (in_wsel),
    .in_fbits    (in_fbits),
    .in_rmode    (in_rmode),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_invalid (out_invalid),
    .out_inexact (out_inexact)
  );

  function automatic logic [63:0] real_to_bits(input real r);
    real two63;
    two63 = 2.0 ** 63;
    if (r >= two63) return 64'h8000_0000_0000_0000 | 64'(longint'(r - two63));
    return 64'(longint'(r));
  endfunction

  function automatic logic [63:0] limit_val(input bit neg, input bit sgn, input int w);
    logic [63:0] one;
    one = 64'd1;
    if (sgn) return neg ? ~((one << (w - 1)) - 1) : (one << (w - 1)) - 1;
    if (neg) return 64'd0;
    return (w == 64) ? {64{1'b1}} : (one << w) - 1;
  endfunction

  task automatic ref_conv(input logic [31:0] op, input bit sgn, input logic [1:0] ws,
                          input int fb, input logic [2:0] rm,
                          output logic [63:0] res, output bit inv, output bit inx);
    int  e;
    int  m;
    int  w;
    bit  neg;
    real v;
    real fl;
    real fr;
    real r;
    e   = int'(op[30:23]);
    m   = int'(op[22:0]);
    neg = op[31];
    w   = (ws == 2'd0) ? 16 : (ws == 2'd1) ? 32 : 64;
    res = '0;
    inv = 1'b0;
    inx = 1'b0;
    if (e == 255 && m != 0) begin
      inv = 1'b1;
      return;
    end
    if (e == 255) begin
      inv = 1'b1;
      res = limit_val(neg, sgn, w);
      return;
    end
    v = real'((e == 0) ? m : m + 8388608) * (2.0 ** (((e == 0) ? 1 : e) - 150 + fb));
    if (neg) v = -v;
    fl = $floor(v);
    fr = v - fl;
    case (rm)
      3'd0: begin
        if (fr > 0.5) r = fl + 1.0;
        else if (fr < 0.5) r = fl;
        else r = ($floor(fl / 2.0) * 2.0 != fl) ? fl + 1.0 : fl;
      end
      3'd1: r = (fr > 0.0) ? fl + 1.0 : fl;
      3'd2: r = fl;
      3'd4: begin
        if (fr > 0.5) r = fl + 1.0;
        else if (fr < 0.5) r = fl;
        else r = (v > 0.0) ? fl + 1.0 : fl;
      end
      default: r = (v >= 0.0) ? fl : ((fr > 0.0) ? fl + 1.0 : fl);
    endcase
    inx = (fr != 0.0);
    if (sgn) begin
      if (r >= 2.0 ** (w - 1) || r < -(2.0 ** (w - 1))) begin
        inv = 1'b1;
        inx = 1'b0;
        res = limit_val(r < 0.0, 1'b1, w);
      end else begin
        res = real_to_bits(r);
      end
    end else begin
      if (r < 0.0) begin
        inv = 1'b1;
        inx = 1'b0;
        res = '0;
      end else if (r >= 2.0 ** w) begin
        inv = 1'b1;
        inx = 1'b0;
        res = limit_val(1'b0, 1'b0, w);
      end else begin
        res = real_to_bits(r);
      end
    end
  endtask

  task automatic compare(input string tag, input logic [31:0] op, input logic [63:0] er,
                         input bit ei, input bit ex);
    n_vec++;
    if (out_valid !== 1'b1 || out_result !== er || out_invalid !== ei || out_inexact !== ex) begin
      n_bad++;
      $display("FAIL %s op=%h got v=%b %h inv=%b inx=%b expected v=1 %h inv=%b inx=%b",
               tag, op, out_valid, out_result, out_invalid, out_inexact, er, ei, ex);
    end
  endtask

  task automatic apply(input logic [31:0] op, input bit sgn, input logic [1:0] ws,
                       input int fb, input logic [2:0] rm, input string tag);
    logic [63:0] er;
    bit          ei;
    bit          ex;
    ref_conv(op, sgn, ws, fb, rm, er, ei, ex);
    @(negedge clk);
    in_op     = op;
    in_signed = sgn;
    in_wsel   = ws;
    in_fbits  = 6'(fb);
    in_rmode  = rm;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
    compare(tag, op, er, ei, ex);
  endtask

  task automatic check_bit(input string tag, input logic got, input logic want);
    n_vec++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s got %b expected %b", tag, got, want);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ea;
    logic [63:0] eb;
    bit          ia;
    bit          xa;
    bit          ib;
    bit          xb;
    int unsigned seed_sink;
    seed_sink = $urandom(32'd20240611);

    repeat (3) @(negedge clk);
    // R1 reset state
    check_bit("R1 out_valid after reset", out_valid, 1'b0);
    check_bit("R1 in_ready after reset", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1 out_valid idle", out_valid, 1'b0);

    // R2 exact scaled integers
    apply(32'h3F800000, 1'b1, 2'd1, 0, 3'd0, "R2 1.0");
    apply(32'h3F800000, 1'b0, 2'd2, 63, 3'd0, "R2 1.0 scaled 2^63 unsigned");
    apply(32'h3F800000, 1'b1, 2'd2, 63, 3'd0, "R5 1.0 scaled 2^63 signed");
    apply(32'h3EC00000, 1'b1, 2'd0, 3, 3'd0, "R2 0.375 x8");
    // R3 halves under every mode
    for (int md = 0; md < 8; md++) begin
      apply(32'h40200000, 1'b1, 2'd1, 0, 3'(md), "R3 +2.5");
      apply(32'hC0200000, 1'b1, 2'd1, 0, 3'(md), "R3 -2.5");
      apply(32'h3FC00000, 1'b1, 2'd1, 0, 3'(md), "R3 +1.5");
      apply(32'hBF000000, 1'b1, 2'd0, 0, 3'(md), "R3 -0.5");
      apply(32'h3FA00000, 1'b0, 2'd0, 0, 3'(md), "R4 1.25");
    end
    // R5 signed limits
    apply(32'h46FFFE00, 1'b1, 2'd0, 0, 3'd0, "R5 32767");
    apply(32'h47000000, 1'b1, 2'd0, 0, 3'd0, "R5 32768");
    apply(32'hC7000000, 1'b1, 2'd0, 0, 3'd0, "R5 -32768");
    apply(32'hC7000100, 1'b1, 2'd0, 0, 3'd0, "R5 -32769");
    apply(32'h4F000000, 1'b1, 2'd1, 0, 3'd3, "R5 2^31");
    apply(32'h5F000000, 1'b1, 2'd3, 0, 3'd3, "R5 2^63");
    apply(32'hDF000000, 1'b1, 2'd2, 0, 3'd3, "R5 -2^63");
    // R6 unsigned negatives
    apply(32'hBF800000, 1'b0, 2'd1, 0, 3'd0, "R6 -1.0");
    apply(32'hBE99999A, 1'b0, 2'd1, 0, 3'd3, "R6 -0.3 to zero");
    apply(32'hBE99999A, 1'b0, 2'd1, 0, 3'd2, "R6 -0.3 down");
    apply(32'h80000000, 1'b0, 2'd0, 5, 3'd0, "R6 -0");
    // R7 unsigned limits
    apply(32'h477FFF00, 1'b0, 2'd0, 0, 3'd0, "R7 65535");
    apply(32'h47800000, 1'b0, 2'd0, 0, 3'd0, "R7 65536");
    apply(32'h477FFF80, 1'b0, 2'd0, 0, 3'd0, "R7 65535.5 rounds up");
    apply(32'h5F800000, 1'b0, 2'd2, 0, 3'd0, "R7 2^64");
    apply(32'h5F7FFFFF, 1'b0, 2'd2, 0, 3'd0, "R7 below 2^64");
    // R8 NaN
    apply(32'h7FC00000, 1'b1, 2'd1, 4, 3'd0, "R8 qnan");
    apply(32'hFF800001, 1'b0, 2'd2, 0, 3'd1, "R8 snan");
    // R9 infinities
    apply(32'h7F800000, 1'b1, 2'd0, 0, 3'd0, "R9 +inf s16");
    apply(32'hFF800000, 1'b1, 2'd2, 0, 3'd0, "R9 -inf s64");
    apply(32'h7F800000, 1'b0, 2'd1, 0, 3'd0, "R9 +inf u32");
    apply(32'hFF800000, 1'b0, 2'd1, 0, 3'd0, "R9 -inf u32");
    // R10 extension
    apply(32'hC2F60000, 1'b1, 2'd0, 0, 3'd0, "R10 -123 s16");
    apply(32'hC2F60000, 1'b1, 2'd1, 0, 3'd0, "R10 -123 s32");
    apply(32'h4B7FFFFF, 1'b0, 2'd1, 0, 3'd0, "R10 u32");
    // R11 subnormals
    apply(32'h00000001, 1'b1, 2'd1, 63, 3'd1, "R11 min sub up");
    apply(32'h80000001, 1'b1, 2'd1, 63, 3'd2, "R11 -min sub down");
    apply(32'h80000001, 1'b0, 2'd1, 63, 3'd2, "R11 -min sub unsigned");
    apply(32'h007FFFFF, 1'b1, 2'd0, 10, 3'd0, "R11 max sub");

    // R1 back-pressure
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    ref_conv(32'h42280000, 1'b1, 2'd1, 2, 3'd0, ea, ia, xa);
    ref_conv(32'hC1100000, 1'b1, 2'd1, 1, 3'd0, eb, ib, xb);
    in_op = 32'h42280000; in_signed = 1'b1; in_wsel = 2'd1; in_fbits = 6'd2; in_rmode = 3'd0;
    in_valid = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    in_op = 32'hC1100000; in_fbits = 6'd1;
    check_bit("R1 in_ready low under stall", in_ready, 1'b0);
    compare("R1 first held", 32'h42280000, ea, ia, xa);
    repeat (3) @(negedge clk);
    compare("R1 still held", 32'h42280000, ea, ia, xa);
    check_bit("R1 in_ready still low", in_ready, 1'b0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare("R1 second after release", 32'hC1100000, eb, ib, xb);
    @(negedge clk);
    check_bit("R1 drained", out_valid, 1'b0);

    // R3 random
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] op;
      int          sel;
      int          fb;
      sel = $urandom_range(0, 9);
      if (sel == 0) op = $urandom();
      else op = {1'($urandom_range(0, 1)), 8'($urandom_range(100, 200)), 23'($urandom())};
      if (sel == 1 || sel == 2) op[12:0] = '0;
      fb = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 63) : $urandom_range(0, 6);
      apply(op, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), fb,
            3'($urandom_range(0, 7)), "R3 random");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule